// File: doc/BRIEF.md
# Addressed Serial Command Receiver

This block is the command front end of a dot-matrix fluorescent display controller. A host drives three wires: a data line, a bit clock and a select line. While select is high, the block takes one data bit on each rising edge of the bit clock. A frame starts with an 8-bit device address that acts as a chip select on a shared bus. An instruction word follows, most significant bit first. When select falls, the frame is checked. It must carry the right address, and the total bit count must match the length its opcode requires. Only then is it committed. A rejected frame is dropped with no trace.

A committed instruction updates held setting registers or fires a one-cycle write strobe. The settings cover display enables, blink settings, the digit count, the intensity duty value and the two memory pointers. The strobes carry address and data for the character, auxiliary and pattern memories, which lie outside this block. Most commands keep the block busy for a fixed execution window. Pointer loads and intensity changes do not. Any frame that commits during the busy window is discarded. The three serial lines are resynchronised to the system clock, so the bit clock must be a good deal slower than the system clock.

Top module: `vfd_cmd_rx`

## Requirements
- R1: After a synchronous active-low reset, every setting register is zero, the display is off, busy is low and no strobe is asserted.
- R2: Bits are taken only on rising bit-clock edges while select is high. A rising select clears the bit count. The frame commits on the falling select edge. The 8 address bits come first, then the instruction, most significant bit first. Bit D(n-1) is the first instruction bit of an n-bit instruction.
- R3: The first received bit must be 1 and the eighth must be 0, with the whole address reading 1,1,1,0,0,1,1,0 in arrival order. Any other address discards the frame.
- R4: The opcode is the top four instruction bits. Opcode 1000 needs exactly 56 instruction bits (64 in total). Every other opcode needs exactly 24 (32 in total). Any other count discards the frame.
- R5: Opcode 0001 loads the main enable from D18, the auxiliary enable from D17, the display-on bit from D16 and the 16-bit digit-enable mask from D15..D0.
- R6: Top bits 101 select blink. D20 is the main blink flag, D19 the auxiliary blink flag, D18..D16 the 3-bit blink rate, and D15..D0 the blink digit mask.
- R7: Opcode 0010 gives a one-cycle shift strobe, with main select from D18, auxiliary select from D17 and direction from D16 (1 means left).
- R8: Opcode 0011 loads the 4-bit digit count from D18..D15.
- R9: Opcode 0100 loads the auxiliary pointer from D18..D15 and the character pointer from D13..D8. It does not raise busy.
- R10: Opcode 0101 loads the 8-bit duty value from D15..D8. It does not raise busy.
- R11: Opcode 0110 gives a one-cycle character-memory write strobe, with address D13..D8 and data D7..D0.
- R12: Opcode 0111 gives a one-cycle auxiliary-memory write strobe, with address D18..D15 and data D14..D7.
- R13: Opcode 1000 gives a one-cycle pattern-memory write strobe, with address D47..D40 and 35 data bits D34..D0.
- R14: The commands of R5-R8 and R11-R13 hold busy high for EXEC_CYC system clocks from commit. A frame that commits while busy is discarded. Opcodes 0000, 1001 and 11xx change nothing and do not raise busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_data | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial bit clock; data taken on its rising edge |
| ser_sel | input | 1 | Select line; high frames a command, falling edge commits |
| busy | output | 1 | Execution window active |
| show_en | output | 1 | Display on |
| show_main | output | 1 | Matrix data enabled |
| show_aux | output | 1 | Auxiliary data enabled |
| show_mask | output | 16 | Enabled digits |
| blink_main | output | 1 | Matrix data blinks |
| blink_aux | output | 1 | Auxiliary data blinks |
| blink_rate | output | 3 | Blink rate code, 0 = stopped |
| blink_mask | output | 16 | Blinking digits |
| digit_count | output | 4 | Number of driven digits |
| duty_level | output | 8 | Intensity duty value |
| ptr_char | output | 6 | Character memory pointer |
| ptr_aux | output | 4 | Auxiliary memory pointer |
| shift_stb | output | 1 | Shift request pulse |
| shift_main | output | 1 | Shift applies to matrix data |
| shift_aux | output | 1 | Shift applies to auxiliary data |
| shift_left | output | 1 | Shift direction, 1 = left |
| cram_we | output | 1 | Character memory write pulse |
| cram_addr | output | 6 | Character memory write address |
| cram_data | output | 8 | Character code to write |
| aram_we | output | 1 | Auxiliary memory write pulse |
| aram_addr | output | 4 | Auxiliary memory write address |
| aram_data | output | 8 | Auxiliary data to write |
| pram_we | output | 1 | Pattern memory write pulse |
| pram_addr | output | 8 | Pattern memory write address |
| pram_data | output | 35 | Pixel pattern to write |

## Verification
The bench targets frame length. It sends a 32-bit frame carrying the long opcode, a 64-bit frame carrying a short opcode, and frames one bit short or one bit long. A design that picked the length from the bit count alone, or took any prefix, would fire a strobe or overwrite a setting from those frames. A one-bit address error and bit-clock pulses sent while select is low check that the address filter and the count clear on select. A design that kept stale bits or matched a partial address would act on them. Frames sent during the busy window, and the zero-time commands, check that busy is raised only by the right opcodes and actually blocks later frames. A scoreboard queue flags any missing, extra or misrouted write and shift strobes, and any with wrong address or data.

// File: rtl/vfd_cmd_pkg.sv
// Package: frame format constants and opcode values shared by the
// receiver modules. Assumes the instruction layout is fixed by the host
// protocol; only timing-related values are module parameters.
package vfd_cmd_pkg;
    localparam int ADDR_W  = 8;   // device address bits
    localparam int SHORT_W = 24;  // ordinary instruction length
    localparam int LONG_W  = 56;  // pattern write instruction length
    localparam int OP_W    = 4;   // opcode width (top of instruction)
    localparam int DIG_W   = 16;  // digit mask width
    localparam int PIX_W   = 35;  // pixels per pattern

    typedef enum logic [OP_W-1:0] {
        OP_SHOW   = 4'b0001,
        OP_SHIFT  = 4'b0010,
        OP_DIGITS = 4'b0011,
        OP_PTRS   = 4'b0100,
        OP_DUTY   = 4'b0101,
        OP_CHARWR = 4'b0110,
        OP_AUXWR  = 4'b0111,
        OP_PATWR  = 4'b1000
    } opcode_e;

    localparam logic [2:0] BLINK_TOP = 3'b101;  // blink: top three bits
endpackage

// File: rtl/vfd_ser_sync.sv
// Module: brings the three serial lines into the system clock domain and
// turns them into single-cycle events. Assumes the bit clock is much
// slower than clk and data is stable around each rising bit-clock edge.
module vfd_ser_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_data,
    input  logic ser_clk,
    input  logic ser_sel,
    output logic bit_stb,
    output logic bit_val,
    output logic sel_rise,
    output logic sel_fall
);
    localparam int LINES = 3;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic             clk_prev;
    logic             sel_prev;

    assign raw = {ser_sel, ser_clk, ser_data};

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic [STAGES-1:0] chain;
        // Purpose: multi-stage synchroniser for one serial line.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], raw[i]};
        end
        assign synced[i] = chain[STAGES-1];
    end

    // Purpose: hold the previous synchronised clock and select levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_prev <= 1'b0;
            sel_prev <= 1'b0;
        end else begin
            clk_prev <= synced[1];
            sel_prev <= synced[2];
        end
    end

    assign bit_val  = synced[0];
    assign bit_stb  = synced[1] & ~clk_prev & synced[2];
    assign sel_rise = synced[2] & ~sel_prev;
    assign sel_fall = ~synced[2] & sel_prev;
endmodule

// File: rtl/vfd_frame_shift.sv
// Module: collects frame bits and, on the select falling edge, checks
// address and length. Assumes bit_stb only arrives while select is high.
// Emits a one-cycle frame_ok with the instruction right-aligned.
module vfd_frame_shift
    import vfd_cmd_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 8'hE6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic              sel_rise,
    input  logic              sel_fall,
    output logic              frame_ok,
    output logic              frame_long,
    output logic [LONG_W-1:0] instr
);
    localparam int TOT_SHORT = ADDR_W + SHORT_W;
    localparam int TOT_LONG  = ADDR_W + LONG_W;
    localparam int CNT_W     = $clog2(TOT_LONG + 2);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(TOT_LONG + 1);

    logic [TOT_LONG-1:0] shreg;
    logic [CNT_W-1:0]    cnt;
    logic                short_ok;
    logic                long_ok;

    // Purpose: shift in bits and count them, saturating past the long length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (sel_rise) begin
            cnt <= '0;
        end else if (bit_stb) begin
            shreg <= {shreg[TOT_LONG-2:0], bit_val};
            if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
        end
    end

    // Purpose: address and length qualification for both frame sizes.
    always_comb begin
        short_ok = (cnt == CNT_W'(TOT_SHORT))
                 && (shreg[TOT_SHORT-1 -: ADDR_W] == DEV_ADDR)
                 && (shreg[SHORT_W-1 -: OP_W] != OP_PATWR);
        long_ok  = (cnt == CNT_W'(TOT_LONG))
                 && (shreg[TOT_LONG-1 -: ADDR_W] == DEV_ADDR)
                 && (shreg[LONG_W-1 -: OP_W] == OP_PATWR);
        frame_ok   = sel_fall & (short_ok | long_ok);
        frame_long = long_ok;
        instr      = long_ok ? shreg[LONG_W-1:0]
                             : {{(LONG_W-SHORT_W){1'b0}}, shreg[SHORT_W-1:0]};
    end

    // R2: a new select window always starts counting from zero
    a_r2_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        sel_rise |=> (cnt == '0));

    // R4: a committed frame has one of the two legal lengths
    a_r4_legal_length: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |-> (cnt == CNT_W'(TOT_SHORT)) || (cnt == CNT_W'(TOT_LONG)));
endmodule

// File: rtl/vfd_busy_timer.sv
// Module: execution window counter. Assumes start only pulses while idle.
// busy stays high for exactly EXEC_CYC cycles after the start edge.
module vfd_busy_timer #(
    parameter int EXEC_CYC = 900
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(EXEC_CYC + 1);

    logic [CW-1:0] left;

    // Purpose: load the window length on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           left <= '0;
        else if (start)       left <= CW'(EXEC_CYC);
        else if (left != '0)  left <= left - 1'b1;
    end

    assign busy = (left != '0);

    // R14: the window is never restarted while it is still running
    a_r14_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);
endmodule

// File: rtl/vfd_cmd_decode.sv
// Module: turns a qualified instruction into setting registers and
// one-cycle memory/shift strobes. Assumes frame_ok is already checked for
// address and length; rejects it here only when busy.
module vfd_cmd_decode
    import vfd_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_ok,
    input  logic              frame_long,
    input  logic [LONG_W-1:0] instr,
    input  logic              busy,
    output logic              start_busy,
    output logic              show_en,
    output logic              show_main,
    output logic              show_aux,
    output logic [DIG_W-1:0]  show_mask,
    output logic              blink_main,
    output logic              blink_aux,
    output logic [2:0]        blink_rate,
    output logic [DIG_W-1:0]  blink_mask,
    output logic [3:0]        digit_count,
    output logic [7:0]        duty_level,
    output logic [5:0]        ptr_char,
    output logic [3:0]        ptr_aux,
    output logic              shift_stb,
    output logic              shift_main,
    output logic              shift_aux,
    output logic              shift_left,
    output logic              cram_we,
    output logic [5:0]        cram_addr,
    output logic [7:0]        cram_data,
    output logic              aram_we,
    output logic [3:0]        aram_addr,
    output logic [7:0]        aram_data,
    output logic              pram_we,
    output logic [7:0]        pram_addr,
    output logic [PIX_W-1:0]  pram_data
);
    logic [OP_W-1:0]    op;
    logic [SHORT_W-1:0] w;
    logic               accept;
    logic               is_blink;
    logic               timed;
    logic               unused_bits;

    // Purpose: opcode selection and execution-time classification.
    always_comb begin
        op       = frame_long ? instr[LONG_W-1 -: OP_W] : instr[SHORT_W-1 -: OP_W];
        w        = instr[SHORT_W-1:0];
        accept   = frame_ok & ~busy;
        is_blink = (op[OP_W-1 -: 3] == BLINK_TOP);
        unique case (op)
            OP_SHOW, OP_SHIFT, OP_DIGITS,
            OP_CHARWR, OP_AUXWR, OP_PATWR: timed = 1'b1;
            default:                       timed = is_blink;
        endcase
        start_busy = accept & timed;
    end

    assign unused_bits = ^{instr[51:48], instr[39:35]};

    // Purpose: held settings, updated only by an accepted instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            show_en     <= 1'b0;
            show_main   <= 1'b0;
            show_aux    <= 1'b0;
            show_mask   <= '0;
            blink_main  <= 1'b0;
            blink_aux   <= 1'b0;
            blink_rate  <= '0;
            blink_mask  <= '0;
            digit_count <= '0;
            duty_level  <= '0;
            ptr_char    <= '0;
            ptr_aux     <= '0;
        end else if (accept) begin
            if (is_blink) begin
                blink_main <= w[20];
                blink_aux  <= w[19];
                blink_rate <= w[18:16];
                blink_mask <= w[15:0];
            end
            case (op)
                OP_SHOW: begin
                    show_main <= w[18];
                    show_aux  <= w[17];
                    show_en   <= w[16];
                    show_mask <= w[15:0];
                end
                OP_DIGITS: digit_count <= w[18:15];
                OP_PTRS: begin
                    ptr_aux  <= w[18:15];
                    ptr_char <= w[13:8];
                end
                OP_DUTY: duty_level <= w[15:8];
                default: ;
            endcase
        end
    end

    // Purpose: single-cycle strobes with their address and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_stb  <= 1'b0;
            shift_main <= 1'b0;
            shift_aux  <= 1'b0;
            shift_left <= 1'b0;
            cram_we    <= 1'b0;
            cram_addr  <= '0;
            cram_data  <= '0;
            aram_we    <= 1'b0;
            aram_addr  <= '0;
            aram_data  <= '0;
            pram_we    <= 1'b0;
            pram_addr  <= '0;
            pram_data  <= '0;
        end else begin
            shift_stb <= accept && (op == OP_SHIFT);
            cram_we   <= accept && (op == OP_CHARWR);
            aram_we   <= accept && (op == OP_AUXWR);
            pram_we   <= accept && (op == OP_PATWR);
            if (accept) begin
                case (op)
                    OP_SHIFT: begin
                        shift_main <= w[18];
                        shift_aux  <= w[17];
                        shift_left <= w[16];
                    end
                    OP_CHARWR: begin
                        cram_addr <= w[13:8];
                        cram_data <= w[7:0];
                    end
                    OP_AUXWR: begin
                        aram_addr <= w[18:15];
                        aram_data <= w[14:7];
                    end
                    OP_PATWR: begin
                        pram_addr <= instr[47:40];
                        pram_data <= instr[PIX_W-1:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    // R7/R11/R12/R13: at most one strobe per cycle
    a_r14_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({shift_stb, cram_we, aram_we, pram_we}));

    // R14: every strobe coincides with the start of a busy window
    a_r14_strobe_opens_window: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_stb | cram_we | aram_we | pram_we) |-> $rose(busy));

    // R10: a duty change never opens a busy window
    a_r10_duty_untimed: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(duty_level) |-> !$rose(busy));

    // R9: a pointer load never opens a busy window
    a_r9_ptr_untimed: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr_char) |-> !$rose(busy));
endmodule

// File: rtl/vfd_cmd_rx.sv
// Module: top of the addressed serial command receiver. Chains the line
// synchroniser, the frame collector, the decoder and the busy timer.
// Assumes ser_clk runs at most at one eighth of clk.
module vfd_cmd_rx
    import vfd_cmd_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR    = 8'hE6,
    parameter int                EXEC_CYC    = 900,
    parameter int                SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ser_data,
    input  logic        ser_clk,
    input  logic        ser_sel,
    output logic        busy,
    output logic        show_en,
    output logic        show_main,
    output logic        show_aux,
    output logic [15:0] show_mask,
    output logic        blink_main,
    output logic        blink_aux,
    output logic [2:0]  blink_rate,
    output logic [15:0] blink_mask,
    output logic [3:0]  digit_count,
    output logic [7:0]  duty_level,
    output logic [5:0]  ptr_char,
    output logic [3:0]  ptr_aux,
    output logic        shift_stb,
    output logic        shift_main,
    output logic        shift_aux,
    output logic        shift_left,
    output logic        cram_we,
    output logic [5:0]  cram_addr,
    output logic [7:0]  cram_data,
    output logic        aram_we,
    output logic [3:0]  aram_addr,
    output logic [7:0]  aram_data,
    output logic        pram_we,
    output logic [7:0]  pram_addr,
    output logic [34:0] pram_data
);
    logic              bit_stb;
    logic              bit_val;
    logic              sel_rise;
    logic              sel_fall;
    logic              frame_ok;
    logic              frame_long;
    logic [LONG_W-1:0] instr;
    logic              start_busy;

    vfd_ser_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .ser_data(ser_data), .ser_clk(ser_clk), .ser_sel(ser_sel),
        .bit_stb(bit_stb), .bit_val(bit_val),
        .sel_rise(sel_rise), .sel_fall(sel_fall)
    );

    vfd_frame_shift #(.DEV_ADDR(DEV_ADDR)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .bit_stb(bit_stb), .bit_val(bit_val),
        .sel_rise(sel_rise), .sel_fall(sel_fall),
        .frame_ok(frame_ok), .frame_long(frame_long), .instr(instr)
    );

    vfd_cmd_decode u_dec (
        .clk(clk), .rst_n(rst_n),
        .frame_ok(frame_ok), .frame_long(frame_long), .instr(instr),
        .busy(busy), .start_busy(start_busy),
        .show_en(show_en), .show_main(show_main), .show_aux(show_aux),
        .show_mask(show_mask),
        .blink_main(blink_main), .blink_aux(blink_aux),
        .blink_rate(blink_rate), .blink_mask(blink_mask),
        .digit_count(digit_count), .duty_level(duty_level),
        .ptr_char(ptr_char), .ptr_aux(ptr_aux),
        .shift_stb(shift_stb), .shift_main(shift_main),
        .shift_aux(shift_aux), .shift_left(shift_left),
        .cram_we(cram_we), .cram_addr(cram_addr), .cram_data(cram_data),
        .aram_we(aram_we), .aram_addr(aram_addr), .aram_data(aram_data),
        .pram_we(pram_we), .pram_addr(pram_addr), .pram_data(pram_data)
    );

    vfd_busy_timer #(.EXEC_CYC(EXEC_CYC)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(start_busy), .busy(busy)
    );

    // R1: nothing is strobed in the first cycle out of reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !(cram_we | aram_we | pram_we | shift_stb));
endmodule

// File: tb/vfd_cmd_rx_tb.sv
// Bench: scoreboard of expected strobes plus direct setting checks.
module vfd_cmd_rx_tb;
    localparam int EXEC = 900;
    localparam logic [7:0] GOOD = 8'hE6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_data = 1'b0, ser_clk = 1'b0, ser_sel = 1'b0;
    logic busy, show_en, show_main, show_aux, blink_main, blink_aux;
    logic [15:0] show_mask, blink_mask;
    logic [2:0] blink_rate;
    logic [3:0] digit_count, ptr_aux, aram_addr;
    logic [7:0] duty_level, cram_data, aram_data, pram_addr;
    logic [5:0] ptr_char, cram_addr;
    logic shift_stb, shift_main, shift_aux, shift_left, cram_we, aram_we, pram_we;
    logic [34:0] pram_data;

    int checks = 0, errors = 0;
    bit done = 0;

    typedef struct { int kind; logic [7:0] addr; logic [34:0] data; } item_t;
    item_t exp_q[$];

    always #10 clk = ~clk;

    vfd_cmd_rx u_dut (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
        .ser_sel(ser_sel), .busy(busy), .show_en(show_en), .show_main(show_main),
        .show_aux(show_aux), .show_mask(show_mask), .blink_main(blink_main),
        .blink_aux(blink_aux), .blink_rate(blink_rate), .blink_mask(blink_mask),
        .digit_count(digit_count), .duty_level(duty_level), .ptr_char(ptr_char),
        .ptr_aux(ptr_aux), .shift_stb(shift_stb), .shift_main(shift_main),
        .shift_aux(shift_aux), .shift_left(shift_left), .cram_we(cram_we),
        .cram_addr(cram_addr), .cram_data(cram_data), .aram_we(aram_we),
        .aram_addr(aram_addr), .aram_data(aram_data), .pram_we(pram_we),
        .pram_addr(pram_addr), .pram_data(pram_data)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input int kind, input logic [7:0] a, input logic [34:0] d);
        item_t it;
        it.kind = kind; it.addr = a; it.data = d;
        exp_q.push_back(it);
    endtask

    // Drive one frame: address bits then nb instruction bits, MSB first.
    task automatic send(input logic [7:0] adr, input logic [63:0] ins, input int nb);
        ser_sel = 1'b1; ser_clk = 1'b0;
        tick(4);
        for (int i = 7; i >= 0; i--) begin
            ser_data = adr[i]; ser_clk = 1'b0; tick(4);
            ser_clk = 1'b1; tick(4);
        end
        for (int i = nb - 1; i >= 0; i--) begin
            ser_data = ins[i]; ser_clk = 1'b0; tick(4);
            ser_clk = 1'b1; tick(4);
        end
        tick(4);
        ser_sel = 1'b0; tick(2);
        ser_clk = 1'b0;
        tick(8);
    endtask

    // After a timed command: busy now, idle once the window has run out.
    task automatic window(input string req);
        chk({req, " busy raised"}, 64'(busy), 64'd1);
        tick(EXEC - 30);
        chk({req, " busy held"}, 64'(busy), 64'd1);
        tick(30);
        chk({req, " busy released"}, 64'(busy), 64'd0);
    endtask

    // Monitor: pop and compare each strobe the design produces.
    always @(negedge clk) begin
        if (rst_n && (shift_stb | cram_we | aram_we | pram_we)) begin
            item_t got, want;
            got.kind = shift_stb ? 0 : cram_we ? 1 : aram_we ? 2 : 3;
            got.addr = cram_we ? 8'(cram_addr) : aram_we ? 8'(aram_addr) :
                       pram_we ? pram_addr : 8'h00;
            got.data = shift_stb ? 35'({shift_main, shift_aux, shift_left}) :
                       cram_we ? 35'(cram_data) : aram_we ? 35'(aram_data) : pram_data;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R7/R11/R12/R13 unexpected strobe: actual kind %0d addr %0h data %0h expected none",
                         got.kind, got.addr, got.data);
            end else begin
                want = exp_q.pop_front();
                if (got.kind != want.kind || got.addr !== want.addr || got.data !== want.data) begin
                    errors++;
                    $display("FAIL R7/R11/R12/R13 strobe: actual %0d/%0h/%0h expected %0d/%0h/%0h",
                             got.kind, got.addr, got.data, want.kind, want.addr, want.data);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R1: reset state
        chk("R1 busy", 64'(busy), 0);
        chk("R1 show", 64'({show_en, show_main, show_aux, show_mask}), 0);
        chk("R1 blink", 64'({blink_main, blink_aux, blink_rate, blink_mask}), 0);
        chk("R1 regs", 64'({digit_count, duty_level, ptr_char, ptr_aux}), 0);

        // R5 display enable
        send(GOOD, 64'h15A5C3, 24);
        chk("R5 show", 64'({show_en, show_main, show_aux, show_mask}), 64'({3'b110, 16'hA5C3}));
        window("R14 R5");

        // R6 blink, both opcode forms
        send(GOOD, 64'hAD0F0F, 24);
        chk("R6 blink A", 64'({blink_main, blink_aux, blink_rate, blink_mask}), 64'({2'b01, 3'd5, 16'h0F0F}));
        window("R14 R6");
        send(GOOD, 64'hB78001, 24);
        chk("R6 blink M", 64'({blink_main, blink_aux, blink_rate, blink_mask}), 64'({2'b10, 3'd7, 16'h8001}));
        window("R14 R6b");

        // R7 shift strobes
        push(0, 8'h00, 35'b111);
        send(GOOD, 64'h270000, 24);
        window("R14 R7");
        push(0, 8'h00, 35'b100);
        send(GOOD, 64'h240000, 24);
        window("R14 R7b");

        // R8 digit count
        send(GOOD, 64'h360000, 24);
        chk("R8 digits", 64'(digit_count), 64'hC);
        window("R14 R8");

        // R9 pointers, untimed
        send(GOOD, 64'h452D00, 24);
        chk("R9 pointers", 64'({ptr_aux, ptr_char}), 64'({4'hA, 6'h2D}));
        chk("R9 no busy", 64'(busy), 0);

        // R10 duty, untimed
        send(GOOD, 64'h50F000, 24);
        chk("R10 duty", 64'(duty_level), 64'hF0);
        chk("R10 no busy", 64'(busy), 0);

        // R11 character write
        push(1, 8'h3E, 35'h4C);
        send(GOOD, 64'h603E4C, 24);
        window("R14 R11");

        // R12 auxiliary write
        push(2, 8'h09, 35'hB6);
        send(GOOD, 64'h74DB00, 24);
        window("R14 R12");

        // R13 pattern writes, 56-bit frames
        push(3, 8'h07, 35'h5A5A5A5A5);
        send(GOOD, (64'h8 << 52) | (64'h07 << 40) | 64'h5A5A5A5A5, 56);
        window("R14 R13");
        push(3, 8'hF3, 35'h7FFFFFFFF);
        send(GOOD, (64'hF << 48) | (64'h8 << 52) | (64'hF3 << 40) | (64'h1F << 35) | 64'h7FFFFFFFF, 56);
        window("R14 R13b");

        // R3 wrong address (last bit flipped)
        send(8'hE7, 64'h511100, 24);
        chk("R3 wrong address duty", 64'(duty_level), 64'hF0);
        send(8'h66, 64'h603101, 24);
        chk("R3 wrong address busy", 64'(busy), 0);

        // R4 length mismatches
        send(GOOD, 64'h50_2200_00_0000_00, 56);
        chk("R4 long frame short op", 64'(duty_level), 64'hF0);
        send(GOOD, 64'h800000, 24);
        chk("R4 short frame long op", 64'(busy), 0);
        send(GOOD, 64'h2833, 23);
        chk("R4 one bit short", 64'(duty_level), 64'hF0);
        send(GOOD, 64'hA04400, 25);
        chk("R4 one bit long", 64'(duty_level), 64'hF0);

        // R14 unused opcodes
        send(GOOD, 64'h0FFFFF, 24);
        chk("R14 op 0000 busy", 64'(busy), 0);
        send(GOOD, 64'hCFFFFF, 24);
        chk("R14 op 1100 busy", 64'(busy), 0);
        chk("R14 unused no change", 64'({show_en, show_mask, digit_count}), 64'({1'b1, 16'hA5C3, 4'hC}));

        // R14 frames committed while busy are dropped
        push(1, 8'h01, 35'h11);
        send(GOOD, 64'h600111, 24);
        send(GOOD, 64'h503300, 24);
        send(GOOD, 64'h600222, 24);
        chk("R14 busy drop duty", 64'(duty_level), 64'hF0);
        chk("R14 still busy", 64'(busy), 1);
        tick(EXEC);
        chk("R14 idle again", 64'(busy), 0);

        // R2 bit-clock pulses with select low are ignored
        ser_sel = 1'b0; ser_data = 1'b1;
        for (int i = 0; i < 5; i++) begin
            ser_clk = 1'b1; tick(4); ser_clk = 1'b0; tick(4);
        end
        send(GOOD, 64'h505A00, 24);
        chk("R2 clean frame after idle clocks", 64'(duty_level), 64'h5A);

        tick(20);
        chk("R7/R11/R12/R13 scoreboard drained", 64'(exp_q.size()), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule